// File: doc/BRIEF.md
# Configurable General-Purpose I/O Ports

This block drives and senses 29 general-purpose pins, arranged as byte-wide ports behind a small byte-wide register interface. Each port has one data register. A write to that register sets the output values of the port's pins. A read returns the pin input levels, sampled through a two-flop synchronizer. Software changes a single pin by reading the port, changing one bit and writing the byte back.

The electrical mode of each pin is set through a two-step window. First a select byte picks the pin. Then a configuration byte is read or written for that pin. The configuration sets three things for the pin:
- whether it drives at all;
- whether it drives push-pull or open-drain;
- whether its pull-up is requested.

The block produces per-pin drive value, output-enable and pull-up controls for the pad ring.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Pin n belongs to port n/8 at bit n%8. The data registers of ports 0, 1, 2 and 3 are at byte addresses 0x00, 0x04, 0x08 and 0x0A.
- R2: A write to a port data register updates the output data of that port's pins. The new data is visible on the pin controls from the cycle after the write.
- R3: A write to address 0x10 stores the pin select as (port << 4) | bit, and a read of 0x10 returns it. Address 0x11 holds the configuration of the selected pin: bit 0 output enable, bit 1 push-pull (open-drain when clear), bit 2 pull-up. Bits 7:3 read as 0 and are dropped on write.
- R4: While a pin's output enable is clear, its pin_oe_o bit is 0, whatever its data bit holds.
- R5: With output enable set and push-pull selected, pin_oe_o is 1 and pin_out_o equals the data bit.
- R6: With output enable set and open-drain selected, a data bit of 1 gives pin_oe_o 0. A data bit of 0 gives pin_oe_o 1 with pin_out_o 0.
- R7: pin_pu_o of a pin follows its configuration bit 2, independent of output enable.
- R8: A read of a port data register returns pin_in_i through two flops. An input change appears on a read after the second rising clock edge, not after the first. Port 3 bits 7:5 read as 0.
- R9: A select write whose lower nibble is 8 or more, or whose pin number is 29 or more, is ignored. The previous select stays in place.
- R10: After reset, every pin has pin_oe_o, pin_out_o and pin_pu_o at 0, and the select and configuration both read 0.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change no pin output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 5 | Register byte address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| pin_in_i | input | 29 | Pin input levels, asynchronous |
| pin_out_o | output | 29 | Per-pin drive value |
| pin_oe_o | output | 29 | Per-pin output enable |
| pin_pu_o | output | 29 | Per-pin pull-up request |

## Verification
Port data is written with distinct patterns (0xA5, 0x3C, 0x96 and 0xFF) at the four irregular offsets. This shows whether each offset reaches the right pins and whether port 3 drops its missing bits. The same data is then viewed under tri-state, push-pull and open-drain settings. A 1 must release an open-drain pin, a 1 must drive a push-pull pin high, and a tri-stated pin must stay silent. Input reads are sampled one edge and two edges after a change, which tells a two-flop path apart from a shorter one. Select codes with an out-of-range nibble or pin number check that the select window keeps its previous pin.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W   = 8;
  localparam int SEL_ADDR = 'h10;
  localparam int CFG_ADDR = 'h11;

  typedef struct packed {
    logic pull_up;    // bit 2
    logic push_pull;  // bit 1
    logic out_en;     // bit 0
  } pin_cfg_t;

  // ports 0..2 on a 4-byte stride, later ports on a 2-byte stride
  function automatic int port_offset(input int p);
    return (p <= 2) ? 4 * p : 8 + 2 * (p - 2);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 29
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_we_i,
  input  logic                cfg_we_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          sel_code_o,
  output pin_cfg_t            cfg_rd_o,
  output logic [NUM_PINS-1:0] out_en_o,
  output logic [NUM_PINS-1:0] push_pull_o,
  output logic [NUM_PINS-1:0] pull_up_o
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [6:0] sel_idx_q, wr_idx;
  logic       sel_valid;
  pin_cfg_t   cfg_q [NUM_PINS];

  // port nibble and 3-bit position form the linear pin index
  assign wr_idx    = {wdata_i[7:4], wdata_i[2:0]};
  assign sel_valid = !wdata_i[3] && (32'(wr_idx) < NUM_PINS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_idx_q <= '0;
    end else if (sel_we_i && sel_valid) begin
      sel_idx_q <= wr_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_PINS; n++) cfg_q[n] <= '0;
    end else if (cfg_we_i) begin
      cfg_q[sel_idx_q[IDX_W-1:0]] <= pin_cfg_t'(wdata_i[2:0]);
    end
  end

  assign sel_code_o = {sel_idx_q[6:3], 1'b0, sel_idx_q[2:0]};
  assign cfg_rd_o   = cfg_q[sel_idx_q[IDX_W-1:0]];

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_cfg_out
    assign out_en_o[n]    = cfg_q[n].out_en;
    assign push_pull_o[n] = cfg_q[n].push_pull;
    assign pull_up_o[n]   = cfg_q[n].pull_up;
  end

  a_r9_bad_sel_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && !sel_valid) |=> $stable(sel_code_o));

  a_r3_cfg_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_rd_o == $past(wdata_i[2:0])));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int NUM_PINS = 29
) (
  input  logic [NUM_PINS-1:0] data_i,
  input  logic [NUM_PINS-1:0] out_en_i,
  input  logic [NUM_PINS-1:0] push_pull_i,
  input  logic [NUM_PINS-1:0] pull_up_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_pu_o
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pad
    // open-drain: a 1 releases the pin, a 0 pulls it low
    assign pin_oe_o[n]  = out_en_i[n] & (push_pull_i[n] | ~data_i[n]);
    assign pin_out_o[n] = data_i[n] & push_pull_i[n];
    assign pin_pu_o[n]  = pull_up_i[n];
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 29,
  parameter int ADDR_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic [7:0]          bus_wdata_i,
  output logic [7:0]          bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_pu_o
);
  localparam int NUM_PORTS = (NUM_PINS + PORT_W - 1) / PORT_W;
  localparam int LAST_BITS = NUM_PINS - (NUM_PORTS - 1) * PORT_W;

  logic [NUM_PORTS-1:0] port_hit;
  logic [NUM_PINS-1:0]  data_q, data_d, pin_sync;
  logic [NUM_PINS-1:0]  out_en_w, push_pull_w, pull_up_w;
  logic                 sel_we, cfg_we;
  logic [7:0]           sel_code;
  pin_cfg_t             cfg_rd;

  assign sel_we = bus_we_i && (bus_addr_i == ADDR_W'(SEL_ADDR));
  assign cfg_we = bus_we_i && (bus_addr_i == ADDR_W'(CFG_ADDR));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
    assign port_hit[p] = bus_we_i && (bus_addr_i == ADDR_W'(port_offset(p)));
  end

  always_comb begin
    data_d = data_q;
    for (int n = 0; n < NUM_PINS; n++) begin
      if (port_hit[n / PORT_W]) data_d[n] = bus_wdata_i[n % PORT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (pin_sync)
  );

  gpio_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_we_i    (sel_we),
    .cfg_we_i    (cfg_we),
    .wdata_i     (bus_wdata_i),
    .sel_code_o  (sel_code),
    .cfg_rd_o    (cfg_rd),
    .out_en_o    (out_en_w),
    .push_pull_o (push_pull_w),
    .pull_up_o   (pull_up_w)
  );

  gpio_pad_ctrl #(.NUM_PINS(NUM_PINS)) u_pad (
    .data_i      (data_q),
    .out_en_i    (out_en_w),
    .push_pull_i (push_pull_w),
    .pull_up_i   (pull_up_w),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .pin_pu_o    (pin_pu_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(SEL_ADDR)) bus_rdata_o = sel_code;
    if (bus_addr_i == ADDR_W'(CFG_ADDR)) bus_rdata_o = {5'b0, cfg_rd};
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr_i == ADDR_W'(port_offset(p))) begin
        for (int b = 0; b < PORT_W; b++) begin
          if (p * PORT_W + b < NUM_PINS) bus_rdata_o[b] = pin_sync[p * PORT_W + b];
        end
      end
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    a_r2_bit_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_hit[n / PORT_W] |=> (data_q[n] == $past(bus_wdata_i[n % PORT_W])));
  end

  a_r4_tristate_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~out_en_w) == '0);

  a_r6_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & pin_out_o & ~push_pull_w) == '0);

  if (LAST_BITS < PORT_W) begin : g_last_chk
    a_r8_last_port_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == ADDR_W'(port_offset(NUM_PORTS - 1)))
        |-> ((bus_rdata_o >> LAST_BITS) == 8'h00));
  end
endmodule

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
  localparam int NP = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_pu;

  int checks = 0;
  int fails  = 0;
  logic [NP-1:0] exp_data = '0;
  logic [2:0]    exp_cfg [NP];

  always #10 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (bus_addr),
    .bus_we_i    (bus_we),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .pin_in_i    (pin_in),
    .pin_out_o   (pin_out),
    .pin_oe_o    (pin_oe),
    .pin_pu_o    (pin_pu)
  );

  function automatic logic [4:0] port_addr(input int p);
    case (p)
      0: return 5'h00;
      1: return 5'h04;
      2: return 5'h08;
      default: return 5'h0A;
    endcase
  endfunction

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic write_port(input int p, input logic [7:0] d);
    bus_write(port_addr(p), d);
    for (int b = 0; b < 8; b++) if (p * 8 + b < NP) exp_data[p * 8 + b] = d[b];
  endtask

  task automatic set_cfg(input int pin, input logic [2:0] c);
    bus_write(5'h10, 8'((pin / 8) << 4) | 8'(pin % 8));
    bus_write(5'h11, {5'b0, c});
    exp_cfg[pin] = c;
  endtask

  task automatic check_pins(input string req);
    logic [NP-1:0] e_oe, e_out, e_pu;
    for (int n = 0; n < NP; n++) begin
      e_oe[n]  = exp_cfg[n][0] & (exp_cfg[n][1] | ~exp_data[n]);
      e_out[n] = exp_data[n] & exp_cfg[n][1];
      e_pu[n]  = exp_cfg[n][2];
    end
    check_eq({req, " pin_oe"},  32'(pin_oe),  32'(e_oe));
    check_eq({req, " pin_out"}, 32'(pin_out), 32'(e_out));
    check_eq({req, " pin_pu"},  32'(pin_pu),  32'(e_pu));
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check_pins("R10 reset");
    bus_read(5'h10, d); check_eq("R10 select after reset", 32'(d), 32'h0);
    bus_read(5'h11, d); check_eq("R10 config after reset", 32'(d), 32'h0);
  endtask

  task automatic t_push_pull;
    for (int n = 0; n < NP; n++) set_cfg(n, 3'b011);
    write_port(0, 8'hA5);
    write_port(1, 8'h3C);
    write_port(2, 8'h96);
    write_port(3, 8'hFF);
    check_pins("R1 R2 R5 push-pull ports");
    check_eq("R1 port3 pins", 32'(pin_out[28:24]), 32'h1F);
    write_port(1, 8'h00);
    check_pins("R2 port1 cleared, others kept");
  endtask

  task automatic t_cfg_window;
    logic [7:0] d;
    set_cfg(19, 3'b101);
    bus_read(5'h10, d); check_eq("R3 select code pin19", 32'(d), 32'h23);
    bus_read(5'h11, d); check_eq("R3 config read pin19", 32'(d), 32'h05);
    bus_write(5'h11, 8'hFA);
    exp_cfg[19] = 3'b010;
    bus_read(5'h11, d); check_eq("R3 config upper bits dropped", 32'(d), 32'h02);
    set_cfg(8, 3'b001);
    bus_read(5'h10, d); check_eq("R3 select code pin8", 32'(d), 32'h10);
    check_pins("R3 config applied");
  endtask

  task automatic t_tristate;
    for (int n = 0; n < 8; n++) set_cfg(n, 3'b010);
    write_port(0, 8'hFF);
    check_pins("R4 tristate push-pull data ones");
    check_eq("R4 port0 oe off", 32'(pin_oe[7:0]), 32'h0);
  endtask

  task automatic t_open_drain;
    for (int n = 8; n < 16; n++) set_cfg(n, 3'b001);
    write_port(1, 8'hF0);
    check_pins("R6 open-drain F0");
    check_eq("R6 port1 oe", 32'(pin_oe[15:8]), 32'h0F);
    check_eq("R6 port1 out", 32'(pin_out[15:8]), 32'h00);
    write_port(1, 8'h5A);
    check_eq("R6 port1 oe 5A", 32'(pin_oe[15:8]), 32'hA5);
  endtask

  task automatic t_pullup;
    set_cfg(20, 3'b100);
    set_cfg(28, 3'b111);
    check_pins("R7 pull-up");
    check_eq("R7 pin20 pull-up no oe", {30'b0, pin_pu[20], pin_oe[20]}, 32'h2);
  endtask

  task automatic t_input_sync;
    logic [7:0] d;
    pin_in = '0;
    repeat (3) @(negedge clk);
    bus_addr = 5'h04;
    pin_in = 29'h1ABC_DE5A;
    @(posedge clk); #1;
    check_eq("R8 one edge keeps old", 32'(bus_rdata), 32'h00);
    @(posedge clk); #1;
    check_eq("R8 two edges port1", 32'(bus_rdata), 32'hDE);
    bus_read(5'h00, d); check_eq("R8 port0 input", 32'(d), 32'h5A);
    bus_read(5'h08, d); check_eq("R8 port2 input", 32'(d), 32'hBC);
    pin_in = '1;
    repeat (3) @(negedge clk);
    bus_read(5'h0A, d); check_eq("R8 port3 upper bits zero", 32'(d), 32'h1F);
  endtask

  task automatic t_bad_select;
    logic [7:0] d;
    bus_write(5'h10, 8'h05);
    bus_write(5'h10, 8'h0F);
    bus_read(5'h10, d); check_eq("R9 nibble >= 8 ignored", 32'(d), 32'h05);
    bus_write(5'h10, 8'h35);
    bus_read(5'h10, d); check_eq("R9 pin29 ignored", 32'(d), 32'h05);
    bus_write(5'h10, 8'h40);
    bus_read(5'h10, d); check_eq("R9 port4 ignored", 32'(d), 32'h05);
    bus_write(5'h10, 8'h34);
    bus_read(5'h10, d); check_eq("R9 pin28 accepted", 32'(d), 32'h34);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    bus_write(5'h01, 8'h00);
    bus_write(5'h0C, 8'h00);
    bus_write(5'h1F, 8'hFF);
    check_pins("R11 unmapped writes");
    bus_read(5'h01, d); check_eq("R11 read 0x01", 32'(d), 32'h0);
    bus_read(5'h0C, d); check_eq("R11 read 0x0C", 32'(d), 32'h0);
    bus_read(5'h1F, d); check_eq("R11 read 0x1F", 32'(d), 32'h0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int n = 0; n < NP; n++) exp_cfg[n] = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pull();
    t_cfg_window();
    t_tristate();
    t_open_drain();
    t_pullup();
    t_input_sync();
    t_bad_select();
    t_unmapped();
    finish_run();
  end
endmodule